// File: doc/BRIEF.md
# Receive lane power sequencer

This block powers one serial transceiver receive lane up and down by stepping a 32-bit lane control word through a fixed series of bit changes. A one-cycle `up_req_i` pulse starts the power-up series. That series takes the lane out of its low-power states, runs and waits for calibration, and pulses the clock-data-recovery reset around the PHY-ready handshake. It then waits for the PCS link flag and writes the observed status word back so that the flag, which is write-one-to-clear, is cleared. A one-cycle `down_req_i` pulse runs the shorter power-down series.

Every minimum gap between steps is a parameter in clock cycles, so a bench can shorten the wait times. Both polls sample their input once per interval and give up after a set number of samples. A failed poll parks the block in an error state and leaves the control word unchanged. The lane, the clocks and the MAC lie outside the block.

Top module: `rxlane_pwr_seq`

## Requirements
- R1: Control word layout: bit 31 override, bit 10 PHY ready, bit 9 CDR reset, bit 8 calibration enable, bits 7:6 sleep (always equal), bit 5 auxiliary IDDQ, bit 4 receiver IDDQ, bit 0 data enable; all other bits are zero.
- R2: After reset the word is 0x000000F0 (both IDDQ bits and both sleep bits set), and busy, done, error and write-enable are low.
- R3: Power-up applies, in order: set override, clear receiver IDDQ, clear auxiliary IDDQ, clear sleep, set calibration enable, clear calibration enable on calibration done, set data enable, clear PHY ready, set CDR reset, set PHY ready, clear CDR reset. A step that does not alter the word produces no change.
- R4: During power-up, at least T_SHORT cycles separate the auxiliary IDDQ clear from the sleep clear. At least T_LONG cycles separate the sleep clear from calibration enable. At least T_SHORT cycles follow each of these: the calibration clear, the PHY-ready clear and the CDR-reset set. At least T_CDR cycles separate the PHY-ready set from the CDR-reset release.
- R5: `cal_done_i` is sampled every CAL_IVL cycles, counted from the cycle in which calibration enable is set. The enable bit clears at the edge of the first sample that sees the input high.
- R6: If CAL_MAX samples in a row see `cal_done_i` low, `err_o` rises exactly CAL_IVL*CAL_MAX cycles after calibration enable was set. The word keeps its value and no done pulse occurs.
- R7: After the CDR-reset release, bit 6 of `irq_sts_i` is sampled every LNK_IVL cycles. On the first sample that sees it set, `irq_wr_en_o` and `done_o` pulse together for one cycle and `irq_wr_o` carries the sampled status word.
- R8: If LNK_MAX link samples all see bit 6 clear, `err_o` rises exactly LNK_IVL*LNK_MAX cycles after the CDR-reset release, with no status write.
- R9: Power-down applies, in order: set override, clear data enable, set sleep, set auxiliary IDDQ, set receiver IDDQ, one step per cycle.
- R10: Requests that arrive while busy are ignored. The sequence in progress completes unchanged, and no second sequence follows it.
- R11: `done_o` is a single-cycle pulse, issued once per completed sequence; `busy_o` is low once it fires.
- R12: `err_o` stays high until the next request, which clears it and starts that request's sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| up_req_i | input | 1 | Power-up request pulse (wins if both requests arrive together) |
| down_req_i | input | 1 | Power-down request pulse |
| cal_done_i | input | 1 | Calibration finished, from the lane |
| irq_sts_i | input | 32 | Lane status word; bit 6 is the PCS link flag |
| ctrl_o | output | 32 | Lane control word |
| busy_o | output | 1 | A sequence is running |
| done_o | output | 1 | One-cycle pulse when a sequence completes |
| err_o | output | 1 | A poll timed out; held until the next request |
| irq_wr_en_o | output | 1 | Write strobe that clears the status flag |
| irq_wr_o | output | 32 | Status value to write back |

## Verification
A step with a gap of G cycles is followed by the next bit change G+1 edges later. Steps without a gap follow one edge apart. A poll started at edge e samples at e+k*interval, so a success or a timeout is due exactly interval, or interval times limit, cycles after the bit change that started the poll. The bench logs every change of the control word and every flag edge with a cycle stamp at the falling clock edge. It then compares the order against a model built from the requirements, the gaps against their minimums, and the poll results against those exact cycle offsets.

// File: rtl/rxl_pkg.sv
package rxl_pkg;
  localparam int unsigned CTRL_W      = 32;
  localparam int unsigned BIT_OVRD    = 31;
  localparam int unsigned BIT_PHY_RDY = 10;
  localparam int unsigned BIT_CDR     = 9;
  localparam int unsigned BIT_CAL     = 8;
  localparam int unsigned BIT_SLP_HI  = 7;
  localparam int unsigned BIT_SLP_LO  = 6;
  localparam int unsigned BIT_AUX     = 5;
  localparam int unsigned BIT_RX      = 4;
  localparam int unsigned BIT_DATA    = 0;
  localparam int unsigned BIT_LINK    = 6;

  typedef enum logic [2:0] {
    ST_IDLE, ST_STEP, ST_WAIT, ST_PCAL, ST_PLNK, ST_ERR
  } seq_st_e;

  typedef struct packed {
    logic       ovrd;
    logic       phy_rdy;
    logic       cdr_rst;
    logic       cal_en;
    logic [1:0] sleep;
    logic       aux_iddq;
    logic       rx_iddq;
    logic       data_en;
  } lane_ctl_t;

  localparam lane_ctl_t CTL_RST = '{ovrd: 1'b0, phy_rdy: 1'b0, cdr_rst: 1'b0,
                                    cal_en: 1'b0, sleep: 2'b11, aux_iddq: 1'b1,
                                    rx_iddq: 1'b1, data_en: 1'b0};

  function automatic logic [CTRL_W-1:0] ctl_to_word(lane_ctl_t c);
    logic [CTRL_W-1:0] w;
    w              = '0;
    w[BIT_OVRD]    = c.ovrd;
    w[BIT_PHY_RDY] = c.phy_rdy;
    w[BIT_CDR]     = c.cdr_rst;
    w[BIT_CAL]     = c.cal_en;
    w[BIT_SLP_HI]  = c.sleep[1];
    w[BIT_SLP_LO]  = c.sleep[0];
    w[BIT_AUX]     = c.aux_iddq;
    w[BIT_RX]      = c.rx_iddq;
    w[BIT_DATA]    = c.data_en;
    return w;
  endfunction
endpackage

// File: rtl/rxl_gap_timer.sv
module rxl_gap_timer #(
  parameter int unsigned TW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [TW-1:0] val_i,
  output logic          zero_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/rxl_poller.sv
module rxl_poller #(
  parameter int unsigned IVL = 100,
  parameter int unsigned MAX = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic sample_i,
  output logic hit_o,
  output logic expire_o
);
  localparam int unsigned IW = $clog2(IVL + 1);
  localparam int unsigned NW = $clog2(MAX + 1);

  logic          run_q;
  logic [IW-1:0] ivl_q;
  logic [NW-1:0] cnt_q;
  logic          tick;

  assign tick     = run_q && (ivl_q == '0);
  assign hit_o    = tick && sample_i;
  assign expire_o = tick && !sample_i && (cnt_q == NW'(MAX - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      ivl_q <= '0;
      cnt_q <= '0;
    end else if (start_i) begin
      run_q <= 1'b1;
      ivl_q <= IW'(IVL - 1);
      cnt_q <= '0;
    end else if (tick) begin
      if (hit_o || expire_o) begin
        run_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
        ivl_q <= IW'(IVL - 1);
      end
    end else if (run_q) begin
      ivl_q <= ivl_q - 1'b1;
    end
  end
endmodule

// File: rtl/rxl_seq_fsm.sv
module rxl_seq_fsm
  import rxl_pkg::*;
#(
  parameter int unsigned T_SHORT = 5,
  parameter int unsigned T_LONG  = 50,
  parameter int unsigned T_CDR   = 3000000,
  parameter int unsigned TW      = 22
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              up_req_i,
  input  logic              down_req_i,
  input  logic              tmr_zero_i,
  input  logic              cal_hit_i,
  input  logic              cal_exp_i,
  input  logic              lnk_hit_i,
  input  logic              lnk_exp_i,
  input  logic [CTRL_W-1:0] irq_sts_i,
  output lane_ctl_t         ctl_o,
  output logic              tmr_load_o,
  output logic [TW-1:0]     tmr_val_o,
  output logic              cal_start_o,
  output logic              lnk_start_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic              irq_wr_en_o,
  output logic [CTRL_W-1:0] irq_wr_o
);
  localparam logic [3:0] UP_CAL  = 4'd4;
  localparam logic [3:0] UP_LAST = 4'd9;
  localparam logic [3:0] DN_LAST = 4'd4;

  seq_st_e           st_q;
  logic [3:0]        idx_q;
  logic              dn_q;
  lane_ctl_t         ctl_q;
  logic              done_q, wr_en_q;
  logic [CTRL_W-1:0] wr_q;
  int unsigned       gap_c;
  seq_st_e           after_c;

  // gap that follows the step applied this cycle
  always_comb begin
    gap_c = 0;
    if (st_q == ST_STEP && !dn_q) begin
      case (idx_q)
        4'd2, 4'd6, 4'd7: gap_c = T_SHORT;
        4'd3:             gap_c = T_LONG;
        4'd8:             gap_c = T_CDR;
        default:          gap_c = 0;
      endcase
    end else if (st_q == ST_PCAL && cal_hit_i) begin
      gap_c = T_SHORT;
    end
  end

  assign after_c     = (gap_c != 0) ? ST_WAIT : ST_STEP;
  assign tmr_load_o  = (gap_c != 0);
  assign tmr_val_o   = TW'(gap_c - 1);
  assign cal_start_o = (st_q == ST_STEP) && !dn_q && (idx_q == UP_CAL);
  assign lnk_start_o = (st_q == ST_STEP) && !dn_q && (idx_q == UP_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      idx_q   <= '0;
      dn_q    <= 1'b0;
      ctl_q   <= CTL_RST;
      done_q  <= 1'b0;
      wr_en_q <= 1'b0;
      wr_q    <= '0;
    end else begin
      done_q  <= 1'b0;
      wr_en_q <= 1'b0;
      case (st_q)
        ST_IDLE, ST_ERR: begin
          if (up_req_i || down_req_i) begin
            st_q  <= ST_STEP;
            idx_q <= '0;
            dn_q  <= !up_req_i;
          end
        end
        ST_STEP: begin
          idx_q <= idx_q + 4'd1;
          if (dn_q) begin
            case (idx_q)
              4'd0:    ctl_q.ovrd     <= 1'b1;
              4'd1:    ctl_q.data_en  <= 1'b0;
              4'd2:    ctl_q.sleep    <= 2'b11;
              4'd3:    ctl_q.aux_iddq <= 1'b1;
              default: ctl_q.rx_iddq  <= 1'b1;
            endcase
            if (idx_q == DN_LAST) begin
              st_q   <= ST_IDLE;
              done_q <= 1'b1;
            end
          end else begin
            case (idx_q)
              4'd0:    ctl_q.ovrd     <= 1'b1;
              4'd1:    ctl_q.rx_iddq  <= 1'b0;
              4'd2:    ctl_q.aux_iddq <= 1'b0;
              4'd3:    ctl_q.sleep    <= 2'b00;
              4'd4:    ctl_q.cal_en   <= 1'b1;
              4'd5:    ctl_q.data_en  <= 1'b1;
              4'd6:    ctl_q.phy_rdy  <= 1'b0;
              4'd7:    ctl_q.cdr_rst  <= 1'b1;
              4'd8:    ctl_q.phy_rdy  <= 1'b1;
              default: ctl_q.cdr_rst  <= 1'b0;
            endcase
            if (idx_q == UP_CAL)       st_q <= ST_PCAL;
            else if (idx_q == UP_LAST) st_q <= ST_PLNK;
            else                       st_q <= after_c;
          end
        end
        ST_WAIT: if (tmr_zero_i) st_q <= ST_STEP;
        ST_PCAL: begin
          if (cal_hit_i) begin
            ctl_q.cal_en <= 1'b0;
            st_q         <= after_c;
          end else if (cal_exp_i) begin
            st_q <= ST_ERR;
          end
        end
        ST_PLNK: begin
          if (lnk_hit_i) begin
            wr_en_q <= 1'b1;
            wr_q    <= irq_sts_i;
            done_q  <= 1'b1;
            st_q    <= ST_IDLE;
          end else if (lnk_exp_i) begin
            st_q <= ST_ERR;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign ctl_o       = ctl_q;
  assign busy_o      = (st_q != ST_IDLE) && (st_q != ST_ERR);
  assign err_o       = (st_q == ST_ERR);
  assign done_o      = done_q;
  assign irq_wr_en_o = wr_en_q;
  assign irq_wr_o    = wr_q;
endmodule

// File: rtl/rxlane_pwr_seq.sv
module rxlane_pwr_seq
  import rxl_pkg::*;
#(
  parameter int unsigned T_SHORT = 5,
  parameter int unsigned T_LONG  = 50,
  parameter int unsigned T_CDR   = 3000000,
  parameter int unsigned CAL_IVL = 100000,
  parameter int unsigned CAL_MAX = 2000,
  parameter int unsigned LNK_IVL = 50000,
  parameter int unsigned LNK_MAX = 2000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              up_req_i,
  input  logic              down_req_i,
  input  logic              cal_done_i,
  input  logic [CTRL_W-1:0] irq_sts_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic              irq_wr_en_o,
  output logic [CTRL_W-1:0] irq_wr_o
);
  localparam int unsigned D_SL = (T_SHORT > T_LONG) ? T_SHORT : T_LONG;
  localparam int unsigned DMAX = (T_CDR > D_SL) ? T_CDR : D_SL;
  localparam int unsigned TW   = $clog2(DMAX + 1);

  lane_ctl_t     ctl;
  logic          tmr_load, tmr_zero;
  logic [TW-1:0] tmr_val;
  logic          cal_start, cal_hit, cal_exp;
  logic          lnk_start, lnk_hit, lnk_exp;

  rxl_seq_fsm #(
    .T_SHORT(T_SHORT), .T_LONG(T_LONG), .T_CDR(T_CDR), .TW(TW)
  ) fsm_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .up_req_i   (up_req_i),
    .down_req_i (down_req_i),
    .tmr_zero_i (tmr_zero),
    .cal_hit_i  (cal_hit),
    .cal_exp_i  (cal_exp),
    .lnk_hit_i  (lnk_hit),
    .lnk_exp_i  (lnk_exp),
    .irq_sts_i  (irq_sts_i),
    .ctl_o      (ctl),
    .tmr_load_o (tmr_load),
    .tmr_val_o  (tmr_val),
    .cal_start_o(cal_start),
    .lnk_start_o(lnk_start),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .err_o      (err_o),
    .irq_wr_en_o(irq_wr_en_o),
    .irq_wr_o   (irq_wr_o)
  );

  rxl_gap_timer #(.TW(TW)) tmr_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(tmr_load),
    .val_i (tmr_val),
    .zero_o(tmr_zero)
  );

  rxl_poller #(.IVL(CAL_IVL), .MAX(CAL_MAX)) cal_poll_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (cal_start),
    .sample_i(cal_done_i),
    .hit_o   (cal_hit),
    .expire_o(cal_exp)
  );

  rxl_poller #(.IVL(LNK_IVL), .MAX(LNK_MAX)) lnk_poll_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (lnk_start),
    .sample_i(irq_sts_i[BIT_LINK]),
    .hit_o   (lnk_hit),
    .expire_o(lnk_exp)
  );

  assign ctrl_o = ctl_to_word(ctl);
endmodule

// File: rtl/rxl_chk.sv
module rxl_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        up_req_i,
  input logic        down_req_i,
  input logic [31:0] ctrl_o,
  input logic        busy_o,
  input logic        done_o,
  input logic        err_o,
  input logic        irq_wr_en_o,
  input logic        wr_link_i
);
  // R1
  sleep_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_o[7] == ctrl_o[6]);

  // R3
  ovrd_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_o[4] |-> ctrl_o[31]);

  // R11
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R11
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  // R7
  clr_with_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_wr_en_o |-> (done_o && wr_link_i));

  // R12
  err_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !busy_o);

  // R6
  err_from_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> $past(busy_o));

  // R10
  idle_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !up_req_i && !down_req_i) |=> $stable(ctrl_o));
endmodule

bind rxlane_pwr_seq rxl_chk chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .up_req_i   (up_req_i),
  .down_req_i (down_req_i),
  .ctrl_o     (ctrl_o),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .err_o      (err_o),
  .irq_wr_en_o(irq_wr_en_o),
  .wr_link_i  (irq_wr_o[6])
);

// File: tb/rxlane_pwr_seq_tb_top.sv
`timescale 1ns/1ps
module rxlane_pwr_seq_tb_top;
  localparam int T_SHORT = 3;
  localparam int T_LONG  = 7;
  localparam int T_CDR   = 20;
  localparam int CAL_IVL = 4;
  localparam int CAL_MAX = 5;
  localparam int LNK_IVL = 3;
  localparam int LNK_MAX = 4;

  // bit masks per R1
  localparam logic [31:0] M_OVRD = 32'h8000_0000;
  localparam logic [31:0] M_PHY  = 32'h0000_0400;
  localparam logic [31:0] M_CDR  = 32'h0000_0200;
  localparam logic [31:0] M_CAL  = 32'h0000_0100;
  localparam logic [31:0] M_SLP  = 32'h0000_00C0;
  localparam logic [31:0] M_AUX  = 32'h0000_0020;
  localparam logic [31:0] M_RX   = 32'h0000_0010;
  localparam logic [31:0] M_DATA = 32'h0000_0001;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b1;
  logic        up_req = 1'b0, down_req = 1'b0, cal_done = 1'b0;
  logic [31:0] irq_sts = '0;
  logic [31:0] ctrl_o, irq_wr_o;
  logic        busy_o, done_o, err_o, irq_wr_en_o;

  always #5 clk = ~clk;

  rxlane_pwr_seq #(
    .T_SHORT(T_SHORT), .T_LONG(T_LONG), .T_CDR(T_CDR),
    .CAL_IVL(CAL_IVL), .CAL_MAX(CAL_MAX), .LNK_IVL(LNK_IVL), .LNK_MAX(LNK_MAX)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .up_req_i(up_req), .down_req_i(down_req),
    .cal_done_i(cal_done), .irq_sts_i(irq_sts), .ctrl_o(ctrl_o), .busy_o(busy_o),
    .done_o(done_o), .err_o(err_o), .irq_wr_en_o(irq_wr_en_o), .irq_wr_o(irq_wr_o)
  );

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // event monitor
  logic [31:0] log_v [64];
  int          log_c [64];
  int          log_n = 0;
  logic [31:0] prev_ctrl = '0, wr_v = '0;
  logic        prev_done = 1'b0, prev_err = 1'b0;
  int done_n = 0, dbl_n = 0, wr_n = 0, done_c = 0, wr_c = 0, err_c = 0;
  int cal_set_c = 0, cal_clr_c = 0, cdr_rel_c = 0;

  always @(negedge clk) begin
    if (ctrl_o !== prev_ctrl) begin
      if (log_n < 64) begin
        log_v[log_n] = ctrl_o;
        log_c[log_n] = cyc;
        log_n++;
      end
      if (ctrl_o[8] && !prev_ctrl[8]) cal_set_c = cyc;
      if (!ctrl_o[8] && prev_ctrl[8]) cal_clr_c = cyc;
      if (!ctrl_o[9] && prev_ctrl[9]) cdr_rel_c = cyc;
    end
    prev_ctrl = ctrl_o;
    if (done_o) begin
      done_n++;
      done_c = cyc;
      if (prev_done) dbl_n++;
    end
    prev_done = done_o;
    if (irq_wr_en_o) begin
      wr_n++;
      wr_c = cyc;
      wr_v = irq_wr_o;
    end
    if (err_o && !prev_err) err_c = cyc;
    prev_err = err_o;
  end

  // expected sequence model
  logic [31:0] exp_v [64];
  int          exp_g [64];
  int          exp_n = 0, acc = 0;
  logic [31:0] mdl = 32'h0000_00F0;

  task automatic check(input string r, input logic ok, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", r, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic step(input logic [31:0] setm, input logic [31:0] clrm, input int gap);
    logic [31:0] nw;
    nw = (mdl & ~clrm) | setm;
    if (nw != mdl) begin
      exp_v[exp_n] = nw;
      exp_g[exp_n] = acc;
      exp_n++;
      acc = 0;
    end
    mdl = nw;
    acc += gap;
  endtask

  task automatic start_run();
    log_n = 0; exp_n = 0; acc = 0;
    done_n = 0; dbl_n = 0; wr_n = 0;
  endtask

  // R3 R4: model of the power-up order and its minimum gaps
  task automatic build_up(input int n);
    for (int i = 0; i < n; i++) begin
      case (i)
        0:  step(M_OVRD, '0, 0);
        1:  step('0, M_RX, 0);
        2:  step('0, M_AUX, T_SHORT);
        3:  step('0, M_SLP, T_LONG);
        4:  step(M_CAL, '0, CAL_IVL);
        5:  step('0, M_CAL, T_SHORT);
        6:  step(M_DATA, '0, 0);
        7:  step('0, M_PHY, T_SHORT);
        8:  step(M_CDR, '0, T_SHORT);
        9:  step(M_PHY, '0, T_CDR);
        default: step('0, M_CDR, 0);
      endcase
    end
  endtask

  // R9: model of the power-down order
  task automatic build_dn();
    step(M_OVRD, '0, 0);
    step('0, M_DATA, 0);
    step(M_SLP, '0, 0);
    step(M_AUX, '0, 0);
    step(M_RX, '0, 0);
  endtask

  task automatic compare_log(input string r);
    int n;
    check(r, log_n == exp_n, log_n, exp_n);
    n = (log_n < exp_n) ? log_n : exp_n;
    for (int i = 0; i < n; i++) begin
      check(r, log_v[i] == exp_v[i], log_v[i], exp_v[i]);
      if (i > 0)
        check({r, " gap"}, (log_c[i] - log_c[i-1]) >= exp_g[i],
              log_c[i] - log_c[i-1], exp_g[i]);
    end
  endtask

  task automatic pulse(input logic up, input logic dn);
    @(negedge clk);
    up_req = up; down_req = dn;
    @(negedge clk);
    up_req = 1'b0; down_req = 1'b0;
    #1;
  endtask

  task automatic wait_end();
    int k;
    k = 0;
    while (!(done_o || err_o) && k < 5000) begin
      tick();
      k++;
    end
    repeat (3) tick();
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    repeat (2) tick();
    rst_ni = 1'b1;
    tick();
    // R2
    check("R2 word", ctrl_o == 32'h0000_00F0, ctrl_o, 32'h0000_00F0);
    check("R2 flags", {busy_o, done_o, err_o, irq_wr_en_o} == 4'b0,
          {busy_o, done_o, err_o, irq_wr_en_o}, 0);
  endtask

  task automatic t_up_ok();
    cal_done = 1'b1;
    irq_sts  = 32'h0000_0041;
    start_run();
    build_up(11);
    pulse(1'b1, 1'b0);
    wait_end();
    compare_log("R3 R4 R1 up");
    check("R11 done count", done_n == 1 && dbl_n == 0, done_n, 1);
    check("R11 busy after", busy_o == 1'b0, busy_o, 0);
    check("R7 write count", wr_n == 1, wr_n, 1);
    check("R7 write data", wr_v == 32'h0000_0041, wr_v, 32'h0000_0041);
    check("R7 with done", wr_c == done_c, wr_c, done_c);
    check("R7 link delay", done_c - cdr_rel_c == LNK_IVL, done_c - cdr_rel_c, LNK_IVL);
    check("R5 first sample", cal_clr_c - cal_set_c == CAL_IVL, cal_clr_c - cal_set_c, CAL_IVL);
  endtask

  task automatic t_up_again();
    cal_done = 1'b0;
    start_run();
    build_up(11);
    fork
      begin
        pulse(1'b1, 1'b0);
        repeat (3) tick();
        pulse(1'b1, 1'b1); // R10: ignored while busy
      end
      begin
        @(posedge ctrl_o[8]);
        @(negedge clk);
        repeat (6) @(negedge clk);
        cal_done = 1'b1;
      end
    join
    wait_end();
    repeat (4) tick();
    compare_log("R10 R3 rerun");
    check("R10 single done", done_n == 1, done_n, 1);
    check("R10 idle after", busy_o == 1'b0, busy_o, 0);
    check("R5 second sample", cal_clr_c - cal_set_c == 2 * CAL_IVL,
          cal_clr_c - cal_set_c, 2 * CAL_IVL);
  endtask

  task automatic t_down();
    start_run();
    build_dn();
    pulse(1'b0, 1'b1);
    wait_end();
    compare_log("R9 down");
    check("R9 final", ctrl_o == 32'h8000_04F0, ctrl_o, 32'h8000_04F0);
    check("R11 down done", done_n == 1 && dbl_n == 0, done_n, 1);
  endtask

  task automatic t_cal_timeout();
    cal_done = 1'b0;
    start_run();
    build_up(5);
    pulse(1'b1, 1'b0);
    wait_end();
    compare_log("R6 partial");
    check("R6 err", err_o == 1'b1, err_o, 1);
    check("R6 err time", err_c - cal_set_c == CAL_IVL * CAL_MAX,
          err_c - cal_set_c, CAL_IVL * CAL_MAX);
    check("R6 word held", ctrl_o == mdl, ctrl_o, mdl);
    check("R6 no done", done_n == 0, done_n, 0);
    repeat (10) tick();
    check("R12 err held", err_o == 1'b1 && ctrl_o == mdl, err_o, 1);
  endtask

  task automatic t_down_from_err();
    start_run();
    build_dn();
    pulse(1'b0, 1'b1);
    check("R12 err cleared", err_o == 1'b0, err_o, 0);
    wait_end();
    compare_log("R12 R9 recover");
    check("R12 done", done_n == 1, done_n, 1);
  endtask

  task automatic t_link_timeout();
    cal_done = 1'b1;
    irq_sts  = 32'h0000_0000;
    start_run();
    build_up(11);
    pulse(1'b1, 1'b0);
    wait_end();
    compare_log("R8 up");
    check("R8 err", err_o == 1'b1, err_o, 1);
    check("R8 err time", err_c - cdr_rel_c == LNK_IVL * LNK_MAX,
          err_c - cdr_rel_c, LNK_IVL * LNK_MAX);
    check("R8 no write", wr_n == 0 && done_n == 0, wr_n, 0);
    check("R8 word held", ctrl_o == mdl, ctrl_o, mdl);
  endtask

  initial begin
    t_reset();
    prev_ctrl = ctrl_o;
    t_up_ok();
    t_up_again();
    t_down();
    t_cal_timeout();
    t_down_from_err();
    t_link_timeout();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule